// File: doc/BRIEF.md
# Shared Message Buffer Flag Controller

This block holds the control and status flags of one message buffer that a host CPU and a CAN protocol engine both use. The CPU reads and writes two byte-wide registers through a port with a per-bit write mask. The engine reports three events: a frame stored into the buffer, a frame sent from it, and a controller soft reset. From the flags the block tells the engine whether it may send a data frame, send a remote-frame request, or store an incoming frame. Frame coding, bit timing, acceptance filtering and the data RAM are handled outside this block.

The new-data flag is the central part. In receive direction it marks unread data. The engine sets it, only the CPU clears it, and it locks out further stores unless overwriting is enabled. In transmit direction the CPU owns it as a "contents complete" handshake. Together with a transmit-hold bit it gates data-frame transmission.

Top module: `msgbuf_handshake`

## Requirements
- R1: After reset every flag is 0. Both registers read 0x00, `tx_data_ok` and `tx_remote_ok` are 0, and `rx_store_ok` is 1.
- R2: Register 1 bit 0 is the new-data flag. In receive direction (register 0 bit 0 = 0), a masked CPU write of 0 clears it and a write of 1 leaves it unchanged.
- R3: In transmit direction (register 0 bit 0 = 1), the CPU may write the new-data flag to either value, and that write does not change the send-request flag (register 1 bit 1).
- R4: The transmit-hold bit (register 1 bit 2) changes on a CPU write only while the buffer is in transmit direction. Writes made in receive direction are ignored.
- R5: `tx_data_ok` is 1 exactly when the direction is transmit, ready (register 0 bit 2) = 1, send-request = 1, new-data = 1 and transmit-hold = 0.
- R6: A pulse on `eng_tx_done` clears send-request in the next cycle and leaves new-data unchanged. A CPU write to send-request in the same cycle takes precedence.
- R7: In receive direction, a pulse on `eng_rx_store` that is accepted (`rx_store_ok` = 1) sets new-data. An engine set beats a same-cycle CPU clear. A store pulse while `rx_store_ok` = 0 changes nothing.
- R8: `rx_store_ok` is 1 only in receive direction, and only when overwrite enable (register 0 bit 1) = 1 or new-data = 0.
- R9: The overwrite status (register 1 bit 3) is set when an accepted store finds new-data already 1 with overwrite enable = 1. It is cleared by a masked CPU write of 0, and a write of 1 has no effect. In receive direction with overwrite enable = 1, it reads 1 whenever transmit-hold is 1.
- R10: `tx_remote_ok` is 1 exactly when the direction is receive, ready = 1 and send-request = 1. Transmit-hold and new-data do not affect it.
- R11: `soft_rst` clears new-data, send-request, transmit-hold and overwrite status in the next cycle and overrides every same-cycle event. Register 0 keeps its value.
- R12: Register 0 reads back direction (bit 0), overwrite enable (bit 1) and ready (bit 2). Each is written only where its mask bit is 1. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | ADDR_W | Register select: 0 config, 1 status |
| cpu_wdata | input | DATA_W | Write data |
| cpu_wmask | input | DATA_W | Per-bit write enable |
| cpu_rdata | output | DATA_W | Read data for `cpu_addr` (combinational) |
| soft_rst | input | 1 | Controller soft reset of the status flags |
| eng_rx_store | input | 1 | Engine finished storing a received frame |
| eng_tx_done | input | 1 | Engine finished a successful transmission |
| tx_data_ok | output | 1 | Engine may send a data frame |
| tx_remote_ok | output | 1 | Engine may send a remote-frame request |
| rx_store_ok | output | 1 | Engine may store an incoming frame |

## Verification
A wrong flag shows at the ports one cycle after the event that caused it. Either a gate output differs, or the status byte differs when it is read. The gate outputs are combinational on the flags, so the bench compares all three gates against its model every cycle. It also compares whichever register is addressed. Collisions need directed cases, because they are only visible in that one cycle: store against clear, transmit-done against a request write, and soft reset against everything. The forced overwrite read-back is also covered directly, since no gate output depends on it.

// File: rtl/mb_hs_pkg.sv
package mb_hs_pkg;
    localparam int unsigned CFG_ADDR = 0;
    localparam int unsigned STS_ADDR = 1;

    localparam int unsigned CFG_DIR  = 0;
    localparam int unsigned CFG_OVR  = 1;
    localparam int unsigned CFG_RDY  = 2;

    localparam int unsigned STS_NEW  = 0;
    localparam int unsigned STS_REQ  = 1;
    localparam int unsigned STS_HOLD = 2;
    localparam int unsigned STS_OVRN = 3;

    localparam int unsigned USED_BITS = 4;

    typedef struct packed {
        logic dir;      // 1 = transmit
        logic ovr_en;
        logic rdy;
        logic new_data;
        logic req;
        logic hold;
        logic ovrn;
    } mb_flags_t;
endpackage

// File: rtl/mb_flag_regs.sv
module mb_flag_regs
    import mb_hs_pkg::*;
#(
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    input  logic              soft_rst,
    input  logic              store_acc,
    input  logic              tx_done,
    output mb_flags_t         flags_q
);
    mb_flags_t flags_d;
    logic      cfg_we;
    logic      sts_we;
    logic      unused_hi;

    assign unused_hi = ^{wdata[DATA_W-1:USED_BITS], wmask[DATA_W-1:USED_BITS]};

    always_comb begin
        flags_d = flags_q;
        cfg_we  = wr && (addr == ADDR_W'(CFG_ADDR));
        sts_we  = wr && (addr == ADDR_W'(STS_ADDR));

        if (cfg_we) begin
            if (wmask[CFG_DIR]) flags_d.dir    = wdata[CFG_DIR];
            if (wmask[CFG_OVR]) flags_d.ovr_en = wdata[CFG_OVR];
            if (wmask[CFG_RDY]) flags_d.rdy    = wdata[CFG_RDY];
        end

        if (tx_done) flags_d.req = 1'b0;

        if (sts_we) begin
            if (wmask[STS_REQ]) flags_d.req = wdata[STS_REQ];
            if (wmask[STS_HOLD] && flags_q.dir) flags_d.hold = wdata[STS_HOLD];
            if (wmask[STS_NEW]) begin
                if (flags_q.dir)             flags_d.new_data = wdata[STS_NEW];
                else if (!wdata[STS_NEW])    flags_d.new_data = 1'b0;
            end
            if (wmask[STS_OVRN] && !wdata[STS_OVRN]) flags_d.ovrn = 1'b0;
        end

        if (store_acc) begin
            flags_d.new_data = 1'b1;
            if (flags_q.new_data && flags_q.ovr_en) flags_d.ovrn = 1'b1;
        end

        if (soft_rst) begin
            flags_d.new_data = 1'b0;
            flags_d.req      = 1'b0;
            flags_d.hold     = 1'b0;
            flags_d.ovrn     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/mb_gates.sv
module mb_gates
    import mb_hs_pkg::*;
(
    input  mb_flags_t flags_q,
    input  logic      eng_rx_store,
    output logic      tx_data_ok,
    output logic      tx_remote_ok,
    output logic      rx_store_ok,
    output logic      store_acc,
    output logic      ovrn_view
);
    always_comb begin
        tx_data_ok   = flags_q.dir && flags_q.rdy && flags_q.req &&
                       flags_q.new_data && !flags_q.hold;
        tx_remote_ok = !flags_q.dir && flags_q.rdy && flags_q.req;
        rx_store_ok  = !flags_q.dir && (flags_q.ovr_en || !flags_q.new_data);
        store_acc    = eng_rx_store && rx_store_ok;
        ovrn_view    = flags_q.ovrn ||
                       (!flags_q.dir && flags_q.ovr_en && flags_q.hold);
    end
endmodule

// File: rtl/msgbuf_handshake.sv
module msgbuf_handshake
    import mb_hs_pkg::*;
#(
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] cpu_wmask,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              soft_rst,
    input  logic              eng_rx_store,
    input  logic              eng_tx_done,
    output logic              tx_data_ok,
    output logic              tx_remote_ok,
    output logic              rx_store_ok
);
    mb_flags_t flags_q;
    logic      store_acc;
    logic      ovrn_view;

    mb_flag_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cpu_wr),
        .addr      (cpu_addr),
        .wdata     (cpu_wdata),
        .wmask     (cpu_wmask),
        .soft_rst  (soft_rst),
        .store_acc (store_acc),
        .tx_done   (eng_tx_done),
        .flags_q   (flags_q)
    );

    mb_gates u_gates (
        .flags_q      (flags_q),
        .eng_rx_store (eng_rx_store),
        .tx_data_ok   (tx_data_ok),
        .tx_remote_ok (tx_remote_ok),
        .rx_store_ok  (rx_store_ok),
        .store_acc    (store_acc),
        .ovrn_view    (ovrn_view)
    );

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == ADDR_W'(CFG_ADDR)) begin
            cpu_rdata[CFG_DIR] = flags_q.dir;
            cpu_rdata[CFG_OVR] = flags_q.ovr_en;
            cpu_rdata[CFG_RDY] = flags_q.rdy;
        end else if (cpu_addr == ADDR_W'(STS_ADDR)) begin
            cpu_rdata[STS_NEW]  = flags_q.new_data;
            cpu_rdata[STS_REQ]  = flags_q.req;
            cpu_rdata[STS_HOLD] = flags_q.hold;
            cpu_rdata[STS_OVRN] = ovrn_view;
        end
    end
endmodule

// File: rtl/mb_hs_chk.sv
module mb_hs_chk
    import mb_hs_pkg::*;
#(
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wmask,
    input logic              soft_rst,
    input logic              eng_rx_store,
    input logic              eng_tx_done,
    input logic              rx_store_ok,
    input logic              tx_data_ok,
    input mb_flags_t         flags_q
);
    logic req_wr;
    assign req_wr = cpu_wr && (cpu_addr == ADDR_W'(STS_ADDR)) && cpu_wmask[STS_REQ];

    // R2
    rx_new_no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_q.dir && !flags_q.new_data && !eng_rx_store) |=> !flags_q.new_data);

    // R4
    hold_frozen_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_q.dir && !soft_rst) |=> $stable(flags_q.hold));

    // R6
    tx_done_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_done && !req_wr) |=> !flags_q.req);

    // R7
    store_sets_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_store && rx_store_ok && !soft_rst) |=> flags_q.new_data);

    // R8
    store_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.new_data && !flags_q.ovr_en) |-> !rx_store_ok);

    // R5
    tx_needs_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_data_ok |-> (flags_q.new_data && !flags_q.hold && flags_q.dir));

    // R11
    soft_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !(flags_q.new_data || flags_q.req || flags_q.hold || flags_q.ovrn));
endmodule

bind msgbuf_handshake mb_hs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wmask    (cpu_wmask),
    .soft_rst     (soft_rst),
    .eng_rx_store (eng_rx_store),
    .eng_tx_done  (eng_tx_done),
    .rx_store_ok  (rx_store_ok),
    .tx_data_ok   (tx_data_ok),
    .flags_q      (flags_q)
);

// File: tb/test_msgbuf_handshake.sv
module test_msgbuf_handshake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [0:0] cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_wmask = '0;
    logic [7:0] cpu_rdata;
    logic       soft_rst = 1'b0;
    logic       eng_rx_store = 1'b0;
    logic       eng_tx_done = 1'b0;
    logic       tx_data_ok, tx_remote_ok, rx_store_ok;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    bit m_dir, m_ovr, m_rdy, m_new, m_req, m_hold, m_ovrn;

    always #4 clk = ~clk;

    msgbuf_handshake i_msgbuf_handshake (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wmask(cpu_wmask), .cpu_rdata(cpu_rdata),
        .soft_rst(soft_rst), .eng_rx_store(eng_rx_store), .eng_tx_done(eng_tx_done),
        .tx_data_ok(tx_data_ok), .tx_remote_ok(tx_remote_ok), .rx_store_ok(rx_store_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_store_ok();
        return !m_dir && (m_ovr || !m_new);
    endfunction

    function automatic logic [7:0] exp_read(input bit a);
        if (!a) return {5'b0, m_rdy, m_ovr, m_dir};
        return {4'b0, m_ovrn || (!m_dir && m_ovr && m_hold), m_hold, m_req, m_new};
    endfunction

    // reference model update
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_dir, m_ovr, m_rdy, m_new, m_req, m_hold, m_ovrn} = '0;
        end else begin
            bit accepted, was_new, was_dir, was_ovr;
            accepted = eng_rx_store && exp_store_ok();
            was_new = m_new; was_dir = m_dir; was_ovr = m_ovr;
            if (cpu_wr && cpu_addr == 1'b0) begin
                if (cpu_wmask[0]) m_dir = cpu_wdata[0];
                if (cpu_wmask[1]) m_ovr = cpu_wdata[1];
                if (cpu_wmask[2]) m_rdy = cpu_wdata[2];
            end
            if (eng_tx_done) m_req = 0;
            if (cpu_wr && cpu_addr == 1'b1) begin
                if (cpu_wmask[1]) m_req = cpu_wdata[1];
                if (cpu_wmask[2] && was_dir) m_hold = cpu_wdata[2];
                if (cpu_wmask[0] && (was_dir || !cpu_wdata[0])) m_new = cpu_wdata[0];
                if (cpu_wmask[3] && !cpu_wdata[3]) m_ovrn = 0;
            end
            if (accepted) begin
                if (was_new && was_ovr) m_ovrn = 1;
                m_new = 1;
            end
            if (soft_rst) {m_new, m_req, m_hold, m_ovrn} = '0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 tx_data_ok", {7'b0, tx_data_ok},
                  {7'b0, m_dir && m_rdy && m_req && m_new && !m_hold});
            check("R10 tx_remote_ok", {7'b0, tx_remote_ok}, {7'b0, !m_dir && m_rdy && m_req});
            check("R8 rx_store_ok", {7'b0, rx_store_ok}, {7'b0, exp_store_ok()});
            check("R12 cpu_rdata", cpu_rdata, exp_read(cpu_addr[0]));
        end
    end

    // one cycle of stimulus, launched just after a falling edge
    task automatic cyc(input bit wr, input bit a, input logic [7:0] d, input logic [7:0] m,
                       input bit st, input bit td, input bit sr);
        cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_wmask = m;
        eng_rx_store = st; eng_tx_done = td; soft_rst = sr;
        @(negedge clk); #1;
        cpu_wr = 0; eng_rx_store = 0; eng_tx_done = 0; soft_rst = 0;
    endtask

    task automatic wr(input bit a, input logic [7:0] d, input logic [7:0] m);
        cyc(1, a, d, m, 0, 0, 0);
    endtask

    task automatic rd(input string req, input bit a, input logic [7:0] exp);
        cpu_addr = a; #1;
        check(req, cpu_rdata, exp);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        rd("R1 status after reset", 1, 8'h00);
        rd("R1 config after reset", 0, 8'h00);
        check("R1 gates after reset", {5'b0, tx_data_ok, tx_remote_ok, rx_store_ok}, 8'h01);

        wr(0, 8'h05, 8'h07);  rd("R12 config tx ready", 0, 8'h05);
        wr(1, 8'h04, 8'h04);  rd("R4 hold set in tx", 1, 8'h04);
        wr(1, 8'h03, 8'h03);  rd("R3 new+req", 1, 8'h07);
        check("R5 blocked by hold", {7'b0, tx_data_ok}, 8'h00);
        wr(1, 8'h00, 8'h04);  rd("R4 hold clear in tx", 1, 8'h03);
        check("R5 send allowed", {7'b0, tx_data_ok}, 8'h01);
        check("R8 no store in tx", {7'b0, rx_store_ok}, 8'h00);
        wr(1, 8'h01, 8'h01);  rd("R3 new write keeps req", 1, 8'h03);
        wr(1, 8'h00, 8'h01);  rd("R3 new clear in tx", 1, 8'h02);
        check("R5 blocked by new=0", {7'b0, tx_data_ok}, 8'h00);
        wr(1, 8'h01, 8'h01);
        cyc(0, 1, 8'h00, 8'h00, 0, 1, 0);
        rd("R6 tx done clears req only", 1, 8'h01);

        wr(1, 8'h04, 8'h04);
        wr(0, 8'h06, 8'h07);  rd("R9 forced overrun view", 1, 8'h0D);
        wr(1, 8'h00, 8'h04);  rd("R4 hold write ignored in rx", 1, 8'h0D);
        wr(1, 8'h00, 8'h01);  rd("R2 clear new in rx", 1, 8'h0C);
        wr(1, 8'h01, 8'h01);  rd("R2 write 1 ignored in rx", 1, 8'h0C);

        cyc(0, 1, 8'h00, 8'h00, 0, 0, 1);
        rd("R11 status cleared", 1, 8'h00);
        rd("R11 config kept", 0, 8'h06);

        cyc(0, 1, 8'h00, 8'h00, 1, 0, 0); rd("R7 store sets new", 1, 8'h01);
        cyc(0, 1, 8'h00, 8'h00, 1, 0, 0); rd("R9 overwrite flagged", 1, 8'h09);
        wr(1, 8'h08, 8'h08);  rd("R9 write 1 no effect", 1, 8'h09);
        wr(1, 8'h00, 8'h08);  rd("R9 overrun cleared", 1, 8'h01);

        wr(0, 8'h04, 8'h07);
        check("R8 lockout", {7'b0, rx_store_ok}, 8'h00);
        cyc(0, 1, 8'h00, 8'h00, 1, 0, 0); rd("R7 refused store ignored", 1, 8'h01);

        wr(0, 8'h06, 8'h07);
        cyc(1, 1, 8'h00, 8'h01, 1, 0, 0); rd("R7 store beats clear", 1, 8'h09);
        wr(1, 8'h02, 8'h02);  rd("R10 request set", 1, 8'h0B);
        check("R10 remote allowed with new=1", {7'b0, tx_remote_ok}, 8'h01);
        cyc(1, 1, 8'h02, 8'h02, 0, 1, 0); rd("R6 cpu write wins", 1, 8'h0B);
        cyc(0, 1, 8'h00, 8'h00, 0, 1, 0);
        check("R10 remote off after done", {7'b0, tx_remote_ok}, 8'h00);
        cyc(1, 1, 8'h0F, 8'h0F, 1, 1, 1); rd("R11 soft reset wins", 1, 8'h00);

        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            cyc(r[0] & r[1], r[2], 8'($urandom), 8'($urandom),
                r[3] & r[4], r[5] & r[6] & r[7], r[8] & r[9] & r[10] & r[11]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule